// File: doc/BRIEF.md
# Four-Load Space Vector Slot Sequencer

This block steps a three-leg, five-switch-per-leg inverter through one switching period that serves four three-phase loads at once. Each load contributes two active vectors whose dwell times arrive precomputed. The block adds the eight dwell times and takes them from the period to get the zero time. It then walks a fixed 24-slot order that places each load's vector pair twice around zero slots. In every slot it drives one five-level state code per leg and reports the slot index.

Each slot is timed by a down-counter loaded at the slot boundary. A slot whose duration works out to zero is passed over. Once started, the block runs period after period without a break. It takes a fresh set of dwell times, vectors and period only at the boundary where a new period begins. For zero slots it chooses, out of the five all-legs-equal zero vectors, the one that changes the fewest legs from the state already being driven. An active vector that is out of range, or that mixes positive and negative codes, is replaced by the same zero choice.

Top module: `svs_seq`

## Requirements
- R1: After reset and until the first `start_i`, the block is idle with `slot_o` = 0, all three leg codes 0 and `ovm_o` = 0.
- R2: Within a period, slots run in ascending index from 0 to 23. A slot s with s mod 3 = 2 is a zero slot. The active slots carry, in order, load2 vector a/b (0,1), load1 a/b (3,4), load1 b/a (6,7), load2 b/a (9,10), load3 a/b (12,13), load4 a/b (15,16), load4 b/a (18,19) and load3 b/a (21,22). A slot of zero duration is skipped and its index never appears.
- R3: Dwell n (n = 0..7) is `dwell_i[n*TW +: TW]`, and load L uses dwells 2(L-1) (vector a) and 2(L-1)+1 (vector b). The first appearance of a vector (slots 0,1,3,4,12,13,15,16) lasts floor(T/2) clock cycles and the second lasts T - floor(T/2). Each slot holds for exactly its duration.
- R4: The zero time Z is the period minus the sum of the eight dwells. Zero slots 2,5,...,20 each last floor(Z/8) cycles, and slot 23 lasts Z - 7*floor(Z/8). Without overmodulation a period therefore lasts exactly `period_i` cycles.
- R5: If the dwell sum exceeds the period, `ovm_o` is 1 for that whole period and Z is taken as 0. Otherwise `ovm_o` is 0.
- R6: In a zero slot all three legs carry one code. That code is the one held by at least two legs in the previous output, or leg A's previous code if all three differ.
- R7: Vector n is `vec_i[9n +: 9]`, with leg A in bits [2:0], leg B in [5:3] and leg C in [8:6]. Each leg is a 3-bit two's-complement code from -2 to 2. A legal active slot drives exactly its latched vector.
- R8: An active vector with any leg code outside -2..2, or with both a negative and a positive leg code, is illegal. Its slot is driven like a zero slot (R6).
- R9: Dwell times, vectors and period are sampled only on the clock edge that begins a period. Changes made mid-period have no effect until the next period. Periods follow one another with no gap.
- R10: `start_i` begins the first period on the next clock edge when idle, and has no effect while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins sequencing when idle |
| period_i | input | TW | Switching period in clock cycles |
| dwell_i | input | 8*TW | Eight active dwell times, packed |
| vec_i | input | 72 | Eight active vectors, three leg codes each |
| leg_a_o | output | 3 | Leg A state code, signed |
| leg_b_o | output | 3 | Leg B state code, signed |
| leg_c_o | output | 3 | Leg C state code, signed |
| slot_o | output | 5 | Index of the slot being driven |
| ovm_o | output | 1 | Overmodulation flag for the current period |

## Verification
Every output is registered. The outputs for a period's first slot appear one clock after the edge on which `start_i` or the previous period's last cycle is sampled. From then on, one clock equals one step of the expected cycle-by-cycle slot list. The bench captures the inputs present at each rising edge. At each period boundary it expands the captured set into a list of per-clock slot indices, one entry per cycle of the period. At every falling edge it compares `slot_o`, the three legs and `ovm_o` against the next list entry. Because of this, a mid-period input change or a stray start pulse only shows up, or fails to show up, at the boundary where the requirements place it.

// File: rtl/svs_pkg.sv
package svs_pkg;
    localparam int unsigned NSLOT = 24;
    localparam int unsigned NDW   = 8;
    localparam int unsigned SLW   = 5;
    localparam int unsigned VECW  = 9;

    typedef logic signed [2:0] leg_t;
    typedef struct packed {
        leg_t c;
        leg_t b;
        leg_t a;
    } vec_t;

    function automatic logic slot_is_zero(input logic [SLW-1:0] s);
        return (s % 5'd3) == 5'd2;
    endfunction

    // second appearance of a load pair in the period (reversed vector order)
    function automatic logic slot_is_second(input logic [SLW-1:0] s);
        int unsigned p;
        p = 32'(s) / 3;
        return (p == 2) || (p == 3) || (p == 6) || (p == 7);
    endfunction

    // dwell / vector index (0..7) that an active slot uses
    function automatic logic [2:0] slot_dwell(input logic [SLW-1:0] s);
        int unsigned p, q, ld, j;
        p = 32'(s) / 3;
        q = 32'(s) % 3;
        case (p)
            0, 3:    ld = 1;
            1, 2:    ld = 0;
            4, 7:    ld = 2;
            default: ld = 3;
        endcase
        j = slot_is_second(s) ? (1 - q) : q;
        return 3'(2 * ld + (j & 1));
    endfunction

    function automatic logic vec_ok(input vec_t v);
        logic rng, neg, pos;
        rng = (v.a >= -3'sd2) && (v.a <= 3'sd2) && (v.b >= -3'sd2) && (v.b <= 3'sd2)
           && (v.c >= -3'sd2) && (v.c <= 3'sd2);
        neg = (v.a < 3'sd0) || (v.b < 3'sd0) || (v.c < 3'sd0);
        pos = (v.a > 3'sd0) || (v.b > 3'sd0) || (v.c > 3'sd0);
        return rng && !(neg && pos);
    endfunction
endpackage

// File: rtl/svs_zero_split.sv
module svs_zero_split import svs_pkg::*; #(
    parameter int unsigned TW = 12
) (
    input  logic [NDW-1:0][TW-1:0] dw_i,
    input  logic [TW-1:0]          per_i,
    output logic [TW-1:0]          z_o,
    output logic                   ovm_o
);
    localparam int unsigned SW = TW + 3;

    logic [SW-1:0] sum;

    always_comb begin
        sum = '0;
        for (int k = 0; k < NDW; k++) begin
            sum = sum + SW'(dw_i[k]);
        end
        ovm_o = sum > SW'(per_i);
        z_o   = ovm_o ? '0 : TW'(SW'(per_i) - sum);
    end
endmodule

// File: rtl/svs_slot_dur.sv
module svs_slot_dur import svs_pkg::*; #(
    parameter int unsigned TW = 12
) (
    input  logic [NDW-1:0][TW-1:0]   dw_i,
    input  logic [TW-1:0]            z_i,
    output logic [NSLOT-1:0][TW-1:0] dur_o
);
    logic [TW-1:0] z_eighth;
    logic [TW-1:0] z_last;

    assign z_eighth = z_i >> 3;
    assign z_last   = (z_i - (z_eighth << 3)) + z_eighth;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if (s % 3 == 2) begin : g_zero
            if (s == NSLOT - 1) begin : g_last
                assign dur_o[s] = z_last;
            end else begin : g_even
                assign dur_o[s] = z_eighth;
            end
        end else begin : g_act
            localparam logic [2:0] DI = slot_dwell(5'(s));
            if (slot_is_second(5'(s))) begin : g_back
                assign dur_o[s] = dw_i[DI] - (dw_i[DI] >> 1);
            end else begin : g_front
                assign dur_o[s] = dw_i[DI] >> 1;
            end
        end
    end
endmodule

// File: rtl/svs_zero_pick.sv
module svs_zero_pick import svs_pkg::*; (
    input  vec_t prev_i,
    output vec_t zero_o
);
    leg_t m;

    always_comb begin
        if (prev_i.a == prev_i.b || prev_i.a == prev_i.c) begin
            m = prev_i.a;
        end else if (prev_i.b == prev_i.c) begin
            m = prev_i.b;
        end else begin
            m = prev_i.a;
        end
        zero_o.a = m;
        zero_o.b = m;
        zero_o.c = m;
    end
endmodule

// File: rtl/svs_seq.sv
module svs_seq import svs_pkg::*; #(
    parameter int unsigned TW = 12
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [TW-1:0]        period_i,
    input  logic [NDW*TW-1:0]    dwell_i,
    input  logic [NDW*VECW-1:0]  vec_i,
    output logic signed [2:0]    leg_a_o,
    output logic signed [2:0]    leg_b_o,
    output logic signed [2:0]    leg_c_o,
    output logic [SLW-1:0]       slot_o,
    output logic                 ovm_o
);
    typedef logic [NDW-1:0][TW-1:0] dwv_t;

    typedef struct packed {
        logic            run;
        logic [SLW-1:0]  slot;
        logic [TW-1:0]   cnt;
        dwv_t            dw;
        logic [TW-1:0]   z;
        logic            ovm;
        vec_t [NDW-1:0]  vec;
        vec_t            leg;
    } st_t;

    st_t st_d, st_q;

    dwv_t           dw_in;
    vec_t [NDW-1:0] vec_in;
    logic [TW-1:0]  z_in;
    logic           ovm_in;

    assign dw_in  = dwell_i;
    assign vec_in = vec_i;

    svs_zero_split #(.TW(TW)) u_split (
        .dw_i  (dw_in),
        .per_i (period_i),
        .z_o   (z_in),
        .ovm_o (ovm_in)
    );

    logic [NSLOT-1:0][TW-1:0] dur_cur;
    logic [NSLOT-1:0][TW-1:0] dur_nxt;

    svs_slot_dur #(.TW(TW)) u_dur_cur (
        .dw_i  (st_q.dw),
        .z_i   (st_q.z),
        .dur_o (dur_cur)
    );

    svs_slot_dur #(.TW(TW)) u_dur_nxt (
        .dw_i  (dw_in),
        .z_i   (z_in),
        .dur_o (dur_nxt)
    );

    vec_t zero_leg;

    svs_zero_pick u_pick (
        .prev_i (st_q.leg),
        .zero_o (zero_leg)
    );

    // next non-empty slot in this period, and first non-empty slot of a new one
    logic           rest_hit, head_hit;
    logic [SLW-1:0] rest_slot, head_slot;

    always_comb begin
        rest_hit  = 1'b0;
        rest_slot = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (SLW'(s) > st_q.slot && dur_cur[s] != '0) begin
                rest_hit  = 1'b1;
                rest_slot = SLW'(s);
            end
        end
        head_hit  = 1'b0;
        head_slot = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (dur_nxt[s] != '0) begin
                head_hit  = 1'b1;
                head_slot = SLW'(s);
            end
        end
    end

    logic           stay, go;
    logic [SLW-1:0] new_slot;
    vec_t           new_vec;

    always_comb begin
        st_d     = st_q;
        stay     = st_q.run && rest_hit;
        go       = st_q.run ? (st_q.cnt <= TW'(1)) : start_i;
        new_slot = stay ? rest_slot : (head_hit ? head_slot : '0);
        new_vec  = stay ? st_q.vec[slot_dwell(new_slot)] : vec_in[slot_dwell(new_slot)];
        if (go) begin
            if (!stay) begin
                st_d.run = 1'b1;
                st_d.dw  = dw_in;
                st_d.z   = z_in;
                st_d.ovm = ovm_in;
                st_d.vec = vec_in;
            end
            st_d.slot = new_slot;
            st_d.cnt  = stay ? dur_cur[new_slot] : (head_hit ? dur_nxt[new_slot] : TW'(1));
            st_d.leg  = (slot_is_zero(new_slot) || !vec_ok(new_vec)) ? zero_leg : new_vec;
        end else if (st_q.run) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic          run_w;
    logic [TW-1:0] cnt_w;

    assign run_w   = st_q.run;
    assign cnt_w   = st_q.cnt;
    assign leg_a_o = st_q.leg.a;
    assign leg_b_o = st_q.leg.b;
    assign leg_c_o = st_q.leg.c;
    assign slot_o  = st_q.slot;
    assign ovm_o   = st_q.ovm;
endmodule

// File: rtl/svs_seq_chk.sv
module svs_seq_chk #(
    parameter int unsigned TW = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              run_i,
    input logic [4:0]        slot_i,
    input logic [TW-1:0]     cnt_i,
    input logic signed [2:0] leg_a_i,
    input logic signed [2:0] leg_b_i,
    input logic signed [2:0] leg_c_i,
    input logic              ovm_i
);
    logic zslot, in_rng, any_neg, any_pos;

    assign zslot   = (slot_i % 5'd3) == 5'd2;
    assign in_rng  = (leg_a_i >= -3'sd2) && (leg_a_i <= 3'sd2) && (leg_b_i >= -3'sd2)
                  && (leg_b_i <= 3'sd2) && (leg_c_i >= -3'sd2) && (leg_c_i <= 3'sd2);
    assign any_neg = (leg_a_i < 3'sd0) || (leg_b_i < 3'sd0) || (leg_c_i < 3'sd0);
    assign any_pos = (leg_a_i > 3'sd0) || (leg_b_i > 3'sd0) || (leg_c_i > 3'sd0);

    AST_IDLE_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> (slot_i == 5'd0 && leg_a_i == 3'sd0 && leg_b_i == 3'sd0
                    && leg_c_i == 3'sd0 && !ovm_i))
        else $error("idle state disturbed"); // R1

    AST_SLOT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> slot_i < 5'd24)
        else $error("slot index out of range"); // R2

    AST_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> cnt_i != '0)
        else $error("slot counter empty while running"); // R3

    AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && $past(run_i) && $past(cnt_i) > TW'(1))
        |-> (slot_i == $past(slot_i) && cnt_i == $past(cnt_i) - 1'b1))
        else $error("slot left before its time"); // R3

    AST_ZERO_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && zslot) |-> (leg_a_i == leg_b_i && leg_b_i == leg_c_i))
        else $error("zero slot legs differ"); // R6

    AST_ZERO_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && $past(run_i) && zslot && slot_i != $past(slot_i))
        |-> ($countones({leg_a_i != $past(leg_a_i), leg_b_i != $past(leg_b_i),
                         leg_c_i != $past(leg_c_i)})
             <= (($past(leg_a_i) != $past(leg_b_i) && $past(leg_a_i) != $past(leg_c_i)
                  && $past(leg_b_i) != $past(leg_c_i)) ? 2 : 1)))
        else $error("zero vector not the least-switching one"); // R6

    AST_LEGAL_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (in_rng && !(any_neg && any_pos)))
        else $error("illegal leg combination driven"); // R8
endmodule

bind svs_seq svs_seq_chk #(.TW(TW)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_w),
    .slot_i  (slot_o),
    .cnt_i   (cnt_w),
    .leg_a_i (leg_a_o),
    .leg_b_i (leg_b_o),
    .leg_c_i (leg_c_o),
    .ovm_i   (ovm_o)
);

// File: tb/sim_svs_seq.sv
module sim_svs_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 12;

    logic clk = 1'b0;
    logic rst_n;
    logic start;
    logic [TW-1:0]   period;
    logic [8*TW-1:0] dwell;
    logic [71:0]     vec;
    logic signed [2:0] la, lb, lc;
    logic [4:0] slot;
    logic       ovm;

    always #(CLK_PERIOD / 2) clk = ~clk;

    svs_seq #(.TW(TW)) u0 (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start),
        .period_i (period),
        .dwell_i  (dwell),
        .vec_i    (vec),
        .leg_a_o  (la),
        .leg_b_o  (lb),
        .leg_c_o  (lc),
        .slot_o   (slot),
        .ovm_o    (ovm)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    string ctx = "R1";

    // inputs as seen by the design at the latest rising edge
    logic [TW-1:0]   cap_per;
    logic [8*TW-1:0] cap_dw;
    logic [71:0]     cap_vec;
    bit              mrun = 1'b0;

    always @(posedge clk) begin
        cap_per <= period;
        cap_dw  <= dwell;
        cap_vec <= vec;
        if (!rst_n) mrun <= 1'b0;
        else if (start) mrun <= 1'b1;
    end

    logic [71:0] lat_vec;
    bit          lat_ovm;
    int lst [0:1023];
    int len = 0;
    int idx = 0;
    int pa = 0, pb = 0, pc = 0;

    function automatic int get_dw(input logic [8*TW-1:0] d, input int k);
        return int'(d[k*TW +: TW]);
    endfunction

    function automatic int get_leg(input logic [71:0] v, input int vi, input int l);
        logic signed [2:0] x;
        x = v[vi*9 + l*3 +: 3];
        return int'(x);
    endfunction

    function automatic bit legal(input logic [71:0] v, input int vi);
        bit neg, pos, rng;
        rng = 1'b1; neg = 1'b0; pos = 1'b0;
        for (int l = 0; l < 3; l++) begin
            int x;
            x = get_leg(v, vi, l);
            if (x < -2 || x > 2) rng = 1'b0;
            if (x < 0) neg = 1'b1;
            if (x > 0) pos = 1'b1;
        end
        return rng && !(neg && pos);
    endfunction

    function automatic bit is_back(input int s);
        int p;
        p = s / 3;
        return (p == 2) || (p == 3) || (p == 6) || (p == 7);
    endfunction

    function automatic int vidx(input int s);
        int p, q, ld;
        p = s / 3;
        q = s % 3;
        case (p)
            0, 3:    ld = 1;
            1, 2:    ld = 0;
            4, 7:    ld = 2;
            default: ld = 3;
        endcase
        return 2 * ld + (is_back(s) ? 1 - q : q);
    endfunction

    // expand the captured inputs into one slot index per clock (R2, R3, R4, R5)
    task automatic build();
        int sum, z, e;
        lat_vec = cap_vec;
        sum = 0;
        for (int k = 0; k < 8; k++) sum += get_dw(cap_dw, k);
        lat_ovm = sum > int'(cap_per);
        z = lat_ovm ? 0 : int'(cap_per) - sum;
        e = z / 8;
        len = 0;
        for (int s = 0; s < 24; s++) begin
            int d, t;
            if (s % 3 == 2) begin
                d = (s == 23) ? z - 7 * e : e;
            end else begin
                t = get_dw(cap_dw, vidx(s));
                d = is_back(s) ? t - t / 2 : t / 2;
            end
            for (int k = 0; k < d; k++) begin
                lst[len] = s;
                len++;
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s (%s) at %0t: actual %0d expected %0d", req, ctx, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!mrun) begin
                // R1: idle outputs
                chk(slot == 5'd0, "R1 slot", int'(slot), 0);
                chk(la == 3'sd0 && lb == 3'sd0 && lc == 3'sd0, "R1 legs", int'(la), 0);
                chk(!ovm, "R1 ovm", int'(ovm), 0);
            end else begin
                int s, ea, eb, ec, m;
                string lreq, sreq;
                if (idx >= len) begin
                    build();
                    idx = 0;
                end
                s = lst[idx];
                if (s % 3 == 2 || !legal(lat_vec, vidx(s))) begin
                    if (pa == pb || pa == pc) m = pa;
                    else if (pb == pc) m = pb;
                    else m = pa;
                    ea = m; eb = m; ec = m;
                    lreq = (s % 3 == 2) ? "R6 zero legs" : "R8 illegal vector legs";
                end else begin
                    ea = get_leg(lat_vec, vidx(s), 0);
                    eb = get_leg(lat_vec, vidx(s), 1);
                    ec = get_leg(lat_vec, vidx(s), 2);
                    lreq = "R7 active legs";
                end
                sreq = (s % 3 == 2) ? "R2/R4 zero slot timing" : "R2/R3 active slot timing";
                chk(int'(slot) == s, sreq, int'(slot), s);
                chk(int'(la) == ea, lreq, int'(la), ea);
                chk(int'(lb) == eb, lreq, int'(lb), eb);
                chk(int'(lc) == ec, lreq, int'(lc), ec);
                chk(ovm == lat_ovm, "R5 ovm", int'(ovm), int'(lat_ovm));
                pa = ea; pb = eb; pc = ec;
                idx++;
            end
        end
    end

    task automatic set_cfg(input int c);
        int t [8];
        int sum, per, base, code;
        int pat [3];
        for (int k = 0; k < 8; k++) t[k] = (c * 5 + k * 3 + 1) % 11;
        case (c)
            0: t = '{10, 6, 8, 4, 12, 2, 5, 7};
            1: t = '{0, 1, 0, 3, 0, 0, 9, 1};
            2: t = '{6, 6, 6, 6, 6, 6, 6, 6};
            default: ;
        endcase
        sum = 0;
        for (int k = 0; k < 8; k++) sum += t[k];
        per = sum + 8 + (c * 7) % 40;
        if (c == 1) per = sum + 20;
        if (c == 2) per = 30;          // R5: overmodulation
        if (c == 4) per = sum + 5;     // R4: only the last zero slot is non-empty
        if (c == 5) per = sum;         // R4: zero time exactly 0
        period = TW'(per);
        for (int k = 0; k < 8; k++) dwell[k*TW +: TW] = TW'(t[k]);
        for (int v = 0; v < 8; v++) begin
            base = (c + v) % 3;
            case ((c + v) % 3)
                0: pat = '{0, 0, 1};
                1: pat = '{0, 1, 2};
                default: pat = '{0, 1, 1};
            endcase
            for (int l = 0; l < 3; l++) begin
                code = (base + pat[l]) % 3;
                if ((c + v) % 2 == 1) code = -code;
                vec[v*9 + l*3 +: 3] = 3'(code);
            end
        end
        if (c == 3) begin
            // R8: mixed signs and an out-of-range code
            vec[1*9 +: 9] = {3'(0), 3'(-1), 3'(1)};
            vec[4*9 +: 9] = {3'(0), 3'(0), 3'(3)};
            vec[7*9 +: 9] = {3'(0), 3'(2), 3'(-2)};
        end
    endtask

    initial begin
        rst_n  = 1'b0;
        start  = 1'b0;
        period = '0;
        dwell  = '0;
        vec    = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);            // R1: idle before start
        set_cfg(0);
        ctx = "R2";
        start = 1'b1;                         // R10: begins on the next edge
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c < 32; c++) begin
            repeat (230) @(negedge clk);
            if (c == 9) begin
                ctx = "R10 start while running";
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            set_cfg(c);                       // R9: applied mid-period
            ctx = "R9 new inputs";
        end
        repeat (300) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        nchk++;
        nerr++;
        $display("FAIL watchdog (R2): actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule